// File: doc/BRIEF.md
# Serial Port Event Status Register

This block holds the eight pending-event flags of an asynchronous serial port and combines them into one interrupt request. The receiver and transmitter next to it report events as strobes, each one clock cycle wide. A receive character was loaded, the parity did not match, the stop bit was missing, a break frame was seen, an address-mode interrupt was acknowledged, the transmit buffer drained, or the transmit shifter finished. The block also watches CPU reads of the receive buffer, so it can tell when a newly arriving character overwrites one that was never read.

Each flag is sticky. Hardware sets a flag and only software clears it. A write to the register clears every bit written as 0 and leaves every bit written as 1 as it was, so an interrupt routine can acknowledge one source without disturbing the others. The interrupt output is the OR of the flags, each qualified by its own mask bit. One exception applies while address mode is active: a pending framing error always requests the interrupt. In that mode a frame with a bad stop bit is also treated as a delivered character.

Top module: `sci_status_reg`

## Requirements
- R1: After reset, status reads 8'h00 and irq is low.
- R2: A strobe sets its flag on the next clock edge. The layout is bit 7 overrun, bit 6 framing error (ev_stop_missing), bit 5 parity error, bit 4 address acknowledge, bit 3 break, bit 2 receive data (ev_rx_load), bit 1 transmit buffer empty, bit 0 transmit shift done.
- R3: A set flag stays set across idle cycles until software clears it.
- R4: A write with wr_en high clears each bit whose wr_data bit is 0 and leaves each bit whose wr_data bit is 1 unchanged.
- R5: No write can set a flag. Writing 8'hFF to a clear register leaves it at 8'h00.
- R6: When a strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: A character load while the previous character is still unread sets bit 7 and bit 2. A receive-buffer read in the same cycle as a load counts as having come first, so that load raises no overrun.
- R8: A receive-buffer read marks the buffer as consumed. The next load then sets only bit 2.
- R9: While addr_mode is high, ev_stop_missing sets bit 6 and also counts as a character load: it sets bit 2 and takes part in overrun detection. With addr_mode low it sets bit 6 only.
- R10: irq equals the OR over all bits of status AND irq_mask, in the same cycle that status changes.
- R11: While addr_mode is high and bit 6 is set, irq is high whatever irq_mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_mode | input | 1 | Receiver is in address mode |
| ev_rx_load | input | 1 | Strobe: character loaded into the receive buffer |
| ev_parity_err | input | 1 | Strobe: received parity mismatch |
| ev_stop_missing | input | 1 | Strobe: received stop bit invalid |
| ev_break | input | 1 | Strobe: line held low for a whole frame |
| ev_addr_ack | input | 1 | Strobe: interrupt acknowledged in address mode |
| ev_tx_buf_empty | input | 1 | Strobe: transmit buffer became empty |
| ev_tx_shift_done | input | 1 | Strobe: transmit shifter finished |
| rx_buf_read | input | 1 | CPU read the receive buffer this cycle |
| wr_en | input | 1 | Software write to the status register |
| wr_data | input | 8 | Write data (0 clears, 1 keeps) |
| irq_mask | input | 8 | Per-bit interrupt enables |
| status | output | 8 | Pending flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every strobe is a one-cycle pulse sampled on the rising edge, and that a CPU read and a character load arriving together are ordered read-first. The bench drives all inputs half a cycle away from the capturing edge and holds each strobe for exactly one cycle. It keeps addr_mode and irq_mask steady between the edge and the sample point, so that the combinational irq is compared against the mask and mode in force when it is sampled.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int STAT_W  = 8;
    localparam int B_OVR   = 7;
    localparam int B_FRM   = 6;
    localparam int B_PAR   = 5;
    localparam int B_ADR   = 4;
    localparam int B_BRK   = 3;
    localparam int B_RXD   = 2;
    localparam int B_TXB   = 1;
    localparam int B_TXS   = 0;

    typedef struct packed {
        logic unread;
    } trk_state_t;
endpackage

// File: rtl/ssr_overrun_track.sv
module ssr_overrun_track (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic read,
    output logic overrun
);
    import ssr_pkg::*;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a read in the same cycle is treated as having come first
        overrun = load && st_q.unread && !read;
        if (load)
            st_d.unread = 1'b1;
        else if (read)
            st_d.unread = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a load on top of an unread character must flag overrun
    a_r7_overrun_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st_q.unread && !read) |-> overrun);

    // R8: overrun only accompanies a load
    a_r8_overrun_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> load);

    // R8: a read without a load leaves the buffer consumed
    a_r8_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !load) |=> !st_q.unread);
endmodule

// File: rtl/ssr_flag_bank.sv
module ssr_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         wr_en,
    input  logic [W-1:0] wr_keep,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < W; i++) begin
            if (wr_en && !wr_keep[i])
                flags_d[i] = 1'b0;
            // hardware set has priority over a clearing write
            if (set[i])
                flags_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    for (genvar g = 0; g < W; g++) begin : g_chk
        // R6: set beats clear
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flags_q[g]);
        // R4: write of 0 clears
        a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_keep[g] && !set[g]) |=> !flags_q[g]);
        // R3: pending flag survives when not cleared
        a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[g] && !(wr_en && !wr_keep[g])) |=> flags_q[g]);
        // R5: software never sets
        a_r5_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags_q[g] && !set[g]) |=> !flags_q[g]);
    end
endmodule

// File: rtl/ssr_irq_gate.sv
module ssr_irq_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] force_en,
    output logic         irq
);
    logic [W-1:0] hit;

    always_comb begin
        for (int i = 0; i < W; i++)
            hit[i] = flags[i] && (mask[i] || force_en[i]);
        irq = |hit;
    end
endmodule

// File: rtl/sci_status_reg.sv
module sci_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_mode,
    input  logic       ev_rx_load,
    input  logic       ev_parity_err,
    input  logic       ev_stop_missing,
    input  logic       ev_break,
    input  logic       ev_addr_ack,
    input  logic       ev_tx_buf_empty,
    input  logic       ev_tx_shift_done,
    input  logic       rx_buf_read,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [7:0] irq_mask,
    output logic [7:0] status,
    output logic       irq
);
    import ssr_pkg::*;

    logic              load_eff;
    logic              ovr_hit;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] force_vec;

    always_comb begin
        // in address mode a bad-stop frame is still delivered
        load_eff = ev_rx_load || (addr_mode && ev_stop_missing);
        set_vec         = '0;
        set_vec[B_OVR]  = ovr_hit;
        set_vec[B_FRM]  = ev_stop_missing;
        set_vec[B_PAR]  = ev_parity_err;
        set_vec[B_ADR]  = ev_addr_ack;
        set_vec[B_BRK]  = ev_break;
        set_vec[B_RXD]  = load_eff;
        set_vec[B_TXB]  = ev_tx_buf_empty;
        set_vec[B_TXS]  = ev_tx_shift_done;
        force_vec        = '0;
        force_vec[B_FRM] = addr_mode;
    end

    ssr_overrun_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_eff),
        .read    (rx_buf_read),
        .overrun (ovr_hit)
    );

    ssr_flag_bank #(.W(STAT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (set_vec),
        .wr_en   (wr_en),
        .wr_keep (wr_data),
        .flags   (status)
    );

    ssr_irq_gate #(.W(STAT_W)) u_gate (
        .flags    (status),
        .mask     (irq_mask),
        .force_en (force_vec),
        .irq      (irq)
    );

    // R9: address-mode framing error delivers the character
    a_r9_addr_frame_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mode && ev_stop_missing) |=> (status[B_RXD] && status[B_FRM]));
    // R10: nothing pending means no request
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
    // R11: framing error in address mode is not maskable
    a_r11_addr_fe_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mode && status[B_FRM]) |-> irq);
endmodule

// File: tb/sim_sci_status_reg.sv
module sim_sci_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_mode = 1'b0;
    logic       ev_rx_load = 1'b0, ev_parity_err = 1'b0, ev_stop_missing = 1'b0;
    logic       ev_break = 1'b0, ev_addr_ack = 1'b0;
    logic       ev_tx_buf_empty = 1'b0, ev_tx_shift_done = 1'b0;
    logic       rx_buf_read = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00, irq_mask = 8'h00;
    logic [7:0] status;
    logic       irq;

    always #10 clk = ~clk;

    sci_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode),
        .ev_rx_load(ev_rx_load), .ev_parity_err(ev_parity_err),
        .ev_stop_missing(ev_stop_missing), .ev_break(ev_break),
        .ev_addr_ack(ev_addr_ack), .ev_tx_buf_empty(ev_tx_buf_empty),
        .ev_tx_shift_done(ev_tx_shift_done), .rx_buf_read(rx_buf_read),
        .wr_en(wr_en), .wr_data(wr_data), .irq_mask(irq_mask),
        .status(status), .irq(irq)
    );

    // event selector bits for the driver
    localparam int E_LOAD = 64, E_PAR = 32, E_STOP = 16, E_BRK = 8;
    localparam int E_ACK = 4, E_TXB = 2, E_TXS = 1;

    int    n_total = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    logic [7:0] m_flags = 8'h00;
    logic       m_unread = 1'b0;
    logic [7:0] q_st[$];
    logic       q_irq[$];
    string      q_tag[$];

    task automatic step(input int ev, input logic am, input logic rd,
                        input logic we, input logic [7:0] wd,
                        input logic [7:0] mk, input string tag);
        logic [7:0] s;
        logic       ld;
        @(negedge clk);
        #1;
        addr_mode        = am;
        ev_rx_load       = (ev & E_LOAD) != 0;
        ev_parity_err    = (ev & E_PAR)  != 0;
        ev_stop_missing  = (ev & E_STOP) != 0;
        ev_break         = (ev & E_BRK)  != 0;
        ev_addr_ack      = (ev & E_ACK)  != 0;
        ev_tx_buf_empty  = (ev & E_TXB)  != 0;
        ev_tx_shift_done = (ev & E_TXS)  != 0;
        rx_buf_read = rd; wr_en = we; wr_data = wd; irq_mask = mk;
        // reference model from the requirements
        ld = ev_rx_load || (am && ev_stop_missing);
        s = 8'h00;
        s[7] = ld && m_unread && !rd;
        s[6] = ev_stop_missing; s[5] = ev_parity_err; s[4] = ev_addr_ack;
        s[3] = ev_break; s[2] = ld; s[1] = ev_tx_buf_empty; s[0] = ev_tx_shift_done;
        m_flags  = s | (we ? (m_flags & wd) : m_flags);
        m_unread = ld ? 1'b1 : (rd ? 1'b0 : m_unread);
        q_st.push_back(m_flags);
        q_irq.push_back((|(m_flags & mk)) || (am && m_flags[6]));
        q_tag.push_back(tag);
        @(posedge clk);
    endtask

    // monitor: compare at the falling edge after each capture
    always @(negedge clk) begin
        if (q_st.size() != 0 && rst_n) begin
            logic [7:0] es;
            logic       ei;
            string      tg;
            es = q_st.pop_front();
            ei = q_irq.pop_front();
            tg = q_tag.pop_front();
            n_total++;
            if (status !== es || irq !== ei) begin
                n_fail++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         tg, status, irq, es, ei);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 8'h00, 8'hFF, "R1");
        // R2 each strobe sets its own bit, then clear
        step(E_TXS, 0, 0, 0, 8'h00, 8'h00, "R2");
        step(E_TXB, 0, 0, 0, 8'h00, 8'h00, "R2");
        step(E_BRK, 0, 0, 0, 8'h00, 8'h00, "R2");
        step(E_ACK, 0, 0, 0, 8'h00, 8'h00, "R2");
        step(E_PAR, 0, 0, 0, 8'h00, 8'h00, "R2");
        step(E_STOP, 0, 0, 0, 8'h00, 8'h00, "R2");
        step(E_LOAD, 0, 0, 0, 8'h00, 8'h00, "R2");
        // R3 idle keeps flags
        step(0, 0, 0, 0, 8'h00, 8'h00, "R3");
        step(0, 0, 0, 0, 8'h00, 8'h00, "R3");
        // R4 clear only bit 5 and bit 0
        step(0, 0, 0, 1, 8'b1101_1110, 8'h00, "R4");
        step(0, 0, 1, 1, 8'h00, 8'h00, "R4");
        // R5 writing ones cannot set
        step(0, 0, 0, 1, 8'hFF, 8'hFF, "R5");
        // R6 set and clear collide
        step(E_PAR | E_TXS, 0, 0, 1, 8'h00, 8'h00, "R6");
        step(0, 0, 0, 1, 8'h00, 8'h00, "R6");
        // R7 overrun on unread data
        step(E_LOAD, 0, 0, 0, 8'h00, 8'h00, "R7");
        step(E_LOAD, 0, 0, 0, 8'h00, 8'h00, "R7");
        step(0, 0, 0, 1, 8'h00, 8'h00, "R7");
        step(E_LOAD, 0, 1, 0, 8'h00, 8'h00, "R7");
        // R8 read then load: no overrun
        step(0, 0, 1, 1, 8'h00, 8'h00, "R8");
        step(E_LOAD, 0, 0, 0, 8'h00, 8'h00, "R8");
        step(0, 0, 1, 1, 8'h00, 8'h00, "R8");
        // R9 address-mode framing error
        step(E_STOP, 1, 0, 0, 8'h00, 8'h00, "R9");
        step(E_STOP, 1, 0, 0, 8'h00, 8'h00, "R9");
        step(0, 0, 1, 1, 8'h00, 8'h00, "R9");
        step(E_STOP, 0, 0, 0, 8'h00, 8'h00, "R9");
        step(0, 0, 0, 1, 8'h00, 8'h00, "R9");
        // R10 masking
        step(E_BRK | E_TXB, 0, 0, 0, 8'h00, 8'h01, "R10");
        step(0, 0, 0, 0, 8'h00, 8'h02, "R10");
        step(0, 0, 0, 0, 8'h00, 8'h08, "R10");
        step(0, 0, 0, 1, 8'h00, 8'hFF, "R10");
        // R11 unmaskable framing error in address mode
        step(E_STOP, 1, 1, 0, 8'h00, 8'h00, "R11");
        step(0, 0, 1, 0, 8'h00, 8'h00, "R11");
        step(0, 1, 0, 0, 8'h00, 8'h00, "R11");
        step(0, 0, 0, 0, 8'h00, 8'h00, "R11");
        @(negedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule